// File: doc/BRIEF.md
# Redundant-Radix Successive Approximation Core

This block is the digital half of a successive approximation converter whose DAC steps are sub-binary: each bit weighs roughly 0.54 of the bit above it, so the sum of the lower bits can absorb a wrong early decision. The core sequences trial bits onto a 12-bit DAC code and reads a single comparator decision each time it resolves a bit. For every bit it keeps, it adds that bit's calibrated weight to a running sum. The corrected binary result is that sum, not the raw trial register.

The upper eight bits are resolved in pairs spaced four positions apart. Both bits of a pair go on together, and then each is decided in turn. The lowest four bits are then resolved one at a time. One conversion always lasts 20 clock cycles. The last three of these are an auto-zero window, in which the trial register and the sum are cleared. The weight table is a constant parameter. Its default is a 1.85-radix series whose full sum lands about 3% above full scale. Bit 12 of the sum serves as an overrange flag, so results somewhat above full scale stay usable.

Top module: `rsar_core`

## Requirements
- R1: With `eoc_o` high, `start_i` sampled high begins a conversion. On the next cycle `eoc_o` is low and `dac_code_o` has exactly bits 11 and 7 set.
- R2: Pair phases cover (11,7), (10,6), (9,5) and (8,4), two cycles per pair. The first cycle decides the upper bit and the second decides the lower bit, and the second cycle also switches on the next pair. Comparator 1 keeps the bit under decision and 0 clears it.
- R3: After the last pair, bit 3 is switched on. Bits 3, 2, 1 and 0 then each take two cycles: a settle cycle, then a decide cycle that also switches on the next lower bit.
- R4: `eoc_o` stays low for exactly 20 cycles after the start edge and then returns high.
- R5: `az_o` is high during cycles 17, 18 and 19 of a conversion, counted from 0 at the first busy cycle, and low otherwise. `dac_code_o` is zero throughout that window.
- R6: The 13-bit sum of the table weights of all kept bits is the output. Bits 11..0 drive `result_o` and bit 12 drives `ovr_o`.
- R7: `result_o` and `ovr_o` take the new value at the edge that ends busy cycle 16. They hold their value at every other edge.
- R8: `start_i` while `eoc_o` is low has no effect on the sequence or on its length.
- R9: After reset, `eoc_o` is 1, and `az_o`, `dac_code_o`, `result_o` and `ovr_o` are 0.
- R10: The default table holds 1939 for bit 11. Each lower weight is the one above times 1000/1850, rounded down after adding 925. With all bits kept, `result_o` is 119 and `ovr_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, sampled while idle |
| comp_i | input | 1 | Comparator: 1 when input >= DAC output |
| dac_code_o | output | 12 | Trial code to the DAC |
| az_o | output | 1 | Comparator auto-zero enable |
| eoc_o | output | 1 | High when idle, low while converting |
| result_o | output | 12 | Corrected result |
| ovr_o | output | 1 | Overrange (bit 12 of the weight sum) |

## Verification
Several properties are checked on every cycle:
- A conversion always ends at its twentieth cycle.
- A request made mid-conversion never disturbs the step count.
- The DAC code is zero whenever auto-zero is active.
- A keep decision never drops an already set bit.
- The sum is clear while idle.
- The outputs move only at the capture edge.

Other behaviour only the bench can show:
- The exact pair and single-bit order.
- Which bits survive for a given analog input.
- The weight sums and the overrange boundary.

The bench shows these by driving a DAC model from the same table and comparing the trial code, auto-zero, flag and result against a reference schedule on every cycle.

// File: rtl/rsar_pkg.sv
package rsar_pkg;
  localparam int DEF_BITS        = 12;
  localparam int DEF_TOP_WEIGHT  = 1939;
  localparam int DEF_RADIX_MILLI = 1850;

  // one (DEF_BITS+1)-bit weight per bit position, LSB position first
  function automatic logic [DEF_BITS*(DEF_BITS+1)-1:0] sub_binary_table(int top, int radix_milli);
    logic [DEF_BITS*(DEF_BITS+1)-1:0] t;
    longint w;
    t = '0;
    w = longint'(top);
    for (int k = DEF_BITS - 1; k >= 0; k--) begin
      t[k*(DEF_BITS+1) +: (DEF_BITS+1)] = (DEF_BITS+1)'(w);
      w = (w * 1000 + longint'(radix_milli / 2)) / longint'(radix_milli);
    end
    return t;
  endfunction
endpackage

// File: rtl/rsar_ctrl.sv
module rsar_ctrl #(
  parameter int N_BITS    = 12,
  parameter int AZ_CYCLES = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  output logic                      busy_o,
  output logic                      load_o,
  output logic                      dec_en_o,
  output logic [$clog2(N_BITS)-1:0] dec_idx_o,
  output logic [N_BITS-1:0]         set_mask_o,
  output logic                      cap_o,
  output logic                      az_o
);
  localparam int GAP      = N_BITS / 3;
  localparam int PAIR_CYC = 2 * GAP;
  localparam int CAP_CYC  = 4 * GAP;
  localparam int LAST_CYC = CAP_CYC + AZ_CYCLES;
  localparam int CW       = $clog2(LAST_CYC + 1);
  localparam int IW       = $clog2(N_BITS);
  localparam logic [CW-1:0] PAIR_END = CW'(PAIR_CYC);
  localparam logic [CW-1:0] CAP_END  = CW'(CAP_CYC);
  localparam logic [CW-1:0] LAST     = CW'(LAST_CYC);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign load_o = start_i && !busy_q;
  assign busy_o = busy_q;
  assign az_o   = busy_q && (cnt_q > CAP_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // step decode: pairs (upper then lower), then single bits (settle, decide)
  always_comb begin
    int p;
    int k;
    p          = int'(cnt_q >> 1);
    k          = int'((cnt_q - PAIR_END) >> 1);
    dec_en_o   = 1'b0;
    dec_idx_o  = '0;
    set_mask_o = '0;
    cap_o      = 1'b0;
    if (busy_q) begin
      if (cnt_q < PAIR_END) begin
        dec_en_o = 1'b1;
        if (!cnt_q[0]) begin
          dec_idx_o = IW'(N_BITS - 1 - p);
        end else begin
          dec_idx_o = IW'(N_BITS - 1 - GAP - p);
          if (p < GAP - 1)
            set_mask_o = (N_BITS'(1) << (N_BITS - 2 - p)) | (N_BITS'(1) << (N_BITS - 2 - GAP - p));
          else
            set_mask_o = N_BITS'(1) << (GAP - 1);
        end
      end else if (cnt_q < CAP_END) begin
        if (cnt_q[0]) begin
          dec_en_o  = 1'b1;
          dec_idx_o = IW'(GAP - 1 - k);
          if (k < GAP - 1) set_mask_o = N_BITS'(1) << (GAP - 2 - k);
        end
      end else if (cnt_q == CAP_END) begin
        cap_o = 1'b1;
      end
    end
  end

  assert_conv_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q == LAST) |=> !busy_q);

  assert_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && cnt_q != LAST) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/rsar_reg.sv
module rsar_reg #(
  parameter int N_BITS = 12
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic                      clr_i,
  input  logic                      dec_en_i,
  input  logic [$clog2(N_BITS)-1:0] dec_idx_i,
  input  logic                      comp_i,
  input  logic [N_BITS-1:0]         set_mask_i,
  output logic [N_BITS-1:0]         sar_o
);
  localparam int GAP = N_BITS / 3;
  localparam int IW  = $clog2(N_BITS);
  localparam logic [N_BITS-1:0] START_CODE =
    (N_BITS'(1) << (N_BITS - 1)) | (N_BITS'(1) << (N_BITS - 1 - GAP));

  for (genvar i = 0; i < N_BITS; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      sar_o[i] <= 1'b0;
      else if (load_i)                                  sar_o[i] <= START_CODE[i];
      else if (clr_i)                                   sar_o[i] <= 1'b0;
      else if (dec_en_i && dec_idx_i == IW'(i) && !comp_i) sar_o[i] <= 1'b0;
      else if (set_mask_i[i])                           sar_o[i] <= 1'b1;
    end
  end

  assert_keep_holds_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_en_i && comp_i && !load_i) |=> ((sar_o & $past(sar_o)) == $past(sar_o)));
endmodule

// File: rtl/rsar_wacc.sv
module rsar_wacc #(
  parameter int N_BITS = 12,
  parameter logic [N_BITS*(N_BITS+1)-1:0] WEIGHTS = '0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      busy_i,
  input  logic                      dec_en_i,
  input  logic [$clog2(N_BITS)-1:0] dec_idx_i,
  input  logic                      comp_i,
  input  logic                      cap_i,
  output logic [N_BITS-1:0]         result_o,
  output logic                      ovr_o
);
  localparam int AW = N_BITS + 1;
  localparam int IW = $clog2(N_BITS);
  localparam int TS = 2 ** IW;

  logic [AW-1:0] wt [TS];
  logic [AW-1:0] w_sel;
  logic [AW-1:0] acc_q;

  for (genvar g = 0; g < TS; g++) begin : g_tab
    if (g < N_BITS) begin : g_used
      assign wt[g] = WEIGHTS[g*AW +: AW];
    end else begin : g_pad
      assign wt[g] = '0;
    end
  end

  assign w_sel = wt[dec_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      result_o <= '0;
      ovr_o    <= 1'b0;
    end else if (cap_i) begin
      result_o <= acc_q[N_BITS-1:0];
      ovr_o    <= acc_q[N_BITS];   // carry of the weight sum
      acc_q    <= '0;
    end else if (dec_en_i && comp_i) begin
      acc_q <= acc_q + w_sel;
    end
  end

  assert_acc_clear_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (acc_q == '0));

  assert_result_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> ($stable(result_o) && $stable(ovr_o)));
endmodule

// File: rtl/rsar_core.sv
module rsar_core #(
  parameter int N_BITS    = rsar_pkg::DEF_BITS,
  parameter int AZ_CYCLES = 3,
  parameter logic [N_BITS*(N_BITS+1)-1:0] WEIGHTS =
    rsar_pkg::sub_binary_table(rsar_pkg::DEF_TOP_WEIGHT, rsar_pkg::DEF_RADIX_MILLI)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              comp_i,
  output logic [N_BITS-1:0] dac_code_o,
  output logic              az_o,
  output logic              eoc_o,
  output logic [N_BITS-1:0] result_o,
  output logic              ovr_o
);
  localparam int IW  = $clog2(N_BITS);
  localparam int GAP = N_BITS / 3;
  localparam logic [N_BITS-1:0] START_CODE =
    (N_BITS'(1) << (N_BITS - 1)) | (N_BITS'(1) << (N_BITS - 1 - GAP));

  logic              busy;
  logic              load;
  logic              dec_en;
  logic [IW-1:0]     dec_idx;
  logic [N_BITS-1:0] set_mask;
  logic              cap;

  rsar_ctrl #(.N_BITS(N_BITS), .AZ_CYCLES(AZ_CYCLES)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .busy_o(busy), .load_o(load), .dec_en_o(dec_en), .dec_idx_o(dec_idx),
    .set_mask_o(set_mask), .cap_o(cap), .az_o(az_o)
  );

  rsar_reg #(.N_BITS(N_BITS)) u_reg (
    .clk_i, .rst_ni, .load_i(load), .clr_i(cap), .dec_en_i(dec_en),
    .dec_idx_i(dec_idx), .comp_i, .set_mask_i(set_mask), .sar_o(dac_code_o)
  );

  rsar_wacc #(.N_BITS(N_BITS), .WEIGHTS(WEIGHTS)) u_wacc (
    .clk_i, .rst_ni, .busy_i(busy), .dec_en_i(dec_en), .dec_idx_i(dec_idx),
    .comp_i, .cap_i(cap), .result_o, .ovr_o
  );

  assign eoc_o = !busy;

  assert_az_dac_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    az_o |-> (dac_code_o == '0));

  assert_start_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && eoc_o) |=> ((dac_code_o == START_CODE) && !eoc_o));
endmodule

// File: tb/rsar_core_tb_top.sv
module rsar_core_tb_top;
  import rsar_pkg::*;
  localparam int NB = 12;
  localparam logic [NB*(NB+1)-1:0] WT = sub_binary_table(DEF_TOP_WEIGHT, DEF_RADIX_MILLI);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic comp_i;
  logic [NB-1:0] dac_code_o, result_o;
  logic az_o, eoc_o, ovr_o;
  int vin = 0;
  int n_run = 0, n_fail = 0;
  int prev_res = 0, prev_ovr = 0;

  always #5 clk = ~clk;

  function automatic int wgt(int b);
    return int'(WT[b*(NB+1) +: (NB+1)]);
  endfunction

  function automatic int dacval(logic [NB-1:0] c);
    int s = 0;
    for (int i = 0; i < NB; i++) if (c[i]) s += wgt(i);
    return s;
  endfunction

  // behavioural DAC + comparator
  assign comp_i = (vin >= dacval(dac_code_o));

  rsar_core dut_i (
    .clk_i(clk), .rst_ni, .start_i, .comp_i, .dac_code_o,
    .az_o, .eoc_o, .result_o, .ovr_o
  );

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d (vin=%0d)", req, what, act, exp, vin);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // reference schedule: trial code per busy cycle and final sum
  task automatic run_conv(int v, int poke);
    int ed[20];
    int code, acc, res, p, b;
    code = (1 << 11) | (1 << 7);
    acc = 0;
    res = 0;
    for (int c = 0; c < 20; c++) begin
      ed[c] = code;
      b = -1;
      if (c < 8) begin
        p = c / 2;
        b = (c % 2 == 0) ? 11 - p : 7 - p;
      end else if (c < 16 && c % 2 == 1) begin
        b = 3 - (c - 8) / 2;
      end
      if (b >= 0) begin
        if (v >= dacval(NB'(code))) acc += wgt(b);
        else code &= ~(1 << b);
      end
      if (c < 8 && c % 2 == 1)
        code |= (p < 3) ? ((1 << (10 - p)) | (1 << (6 - p))) : (1 << 3);
      else if (c >= 8 && c < 16 && c % 2 == 1 && b > 0)
        code |= 1 << (b - 1);
      else if (c == 16) begin
        res = acc;
        code = 0;
      end
    end
    vin = v;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    for (int c = 0; c < 20; c++) begin
      if (c == 0) chk("R1", "dac at first busy cycle", int'(dac_code_o), (1 << 11) | (1 << 7));
      chk("R4", "eoc while busy", int'(eoc_o), 0);
      chk(c < 8 ? "R2" : (c < 16 ? "R3" : "R5"), $sformatf("dac cycle %0d", c), int'(dac_code_o), ed[c]);
      chk("R5", $sformatf("az cycle %0d", c), int'(az_o), (c >= 17) ? 1 : 0);
      chk("R7", $sformatf("result cycle %0d", c), int'(result_o), (c >= 17) ? (res & 4095) : prev_res);
      chk("R7", $sformatf("ovr cycle %0d", c), int'(ovr_o), (c >= 17) ? (res >> 12) & 1 : prev_ovr);
      start_i = (c == poke) ? 1'b1 : 1'b0;  // R8: request mid-conversion
      @(negedge clk);
    end
    start_i = 1'b0;
    chk("R4", "eoc after 20 cycles", int'(eoc_o), 1);
    chk("R6", "result", int'(result_o), res & 4095);
    chk("R6", "ovr", int'(ovr_o), (res >> 12) & 1);
    chk("R6", "sum not above input", (res <= v) ? 1 : 0, 1);
    prev_res = res & 4095;
    prev_ovr = (res >> 12) & 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seed;
    repeat (3) @(negedge clk);
    chk("R9", "eoc in reset", int'(eoc_o), 1);
    chk("R9", "az in reset", int'(az_o), 0);
    chk("R9", "dac in reset", int'(dac_code_o), 0);
    chk("R9", "result in reset", int'(result_o), 0);
    chk("R9", "ovr in reset", int'(ovr_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10", "top weight", wgt(11), 1939);
    chk("R10", "lsb weight", wgt(0), 2);

    run_conv(0, -1);
    chk("R2", "zero input result", int'(result_o), 0);
    run_conv(4215, -1);
    chk("R10", "all kept result", int'(result_o), 119);
    chk("R10", "all kept ovr", int'(ovr_o), 1);
    run_conv(5000, -1);
    run_conv(1000, -1);
    run_conv(2048, -1);
    run_conv(4095, -1);
    run_conv(4096, -1);
    run_conv(3, -1);
    run_conv(1500, 5);
    run_conv(2500, 19);
    run_conv(3333, 0);
    repeat (3) @(negedge clk);
    chk("R8", "idle dac", int'(dac_code_o), 0);
    chk("R4", "idle eoc", int'(eoc_o), 1);
    seed = 12345;
    for (int i = 0; i < 24; i++) begin
      seed = (seed * 1103515 + 12345) & 32'h7fffffff;
      run_conv(seed % 4300, (i % 3 == 0) ? (i % 20) : -1);
    end
    finish_run();
  end
endmodule